// File: doc/BRIEF.md
# Addressed Peripheral I/O Port

This block is one device interface hanging on a shared processor I/O bus. It watches the bus address and the strobe on every clock. It reacts only when the strobe is high and the address equals its configured device address. The 2-bit command code presented with the address selects one of four operations: a control command that passes a function value to the device, a status query, a processor-to-device data transfer, or a device-to-processor data transfer.

Each direction goes through a one-word holding register. The outgoing word leaves toward the device on a valid/ready stream. Once `pout_valid` is high, the word and the valid stay unchanged until the device raises `pout_ready`, and the word is taken in the cycle where both are high. The incoming word arrives on a second valid/ready stream. `pin_ready` is high exactly while the input register is empty, so the device is held off until the processor has read the previous word. Read results come back one cycle after the command, qualified by `bus_rvalid`. `bus_rdata` stays at zero in every other cycle, so an unselected device never drives the shared return path.

Top module: `bus_io_port`

## Requirements
- R1: A command is accepted on a rising clock edge only when `bus_stb` is 1 and `bus_addr` equals `DEV_ADDR`. In any other cycle no internal state changes because of the command inputs, and no read response or control pulse follows.
- R2: The command codes are 2'b00 control, 2'b01 status, 2'b10 data out and 2'b11 data in.
- R3: An accepted control command raises `ctl_pulse` for the following cycle. In that cycle `ctl_func` equals `bus_wdata[FUNC_W-1:0]`, and `ctl_func` holds that value until the next control command. The function value zero also clears the error flag. Any other function value leaves the error flag unchanged.
- R4: An accepted status command gives `bus_rvalid`=1 in the next cycle. `bus_rdata` then carries the status at the time of the command: bit 0 busy, bit 1 error, bit 2 input word held, bit 3 output register empty. All higher bits are 0.
- R5: An accepted data-out command with the output register empty stores `bus_wdata` there. In the next cycle `pout_valid`=1, `pout_data` carries that word, and busy is set.
- R6: While `pout_valid` is 1 and `pout_ready` is 0, `pout_valid` and `pout_data` hold. When both are 1 at an edge, the register empties: `pout_valid` and busy are 0 in the next cycle.
- R7: A data-out command while the output register is full sets the error flag and leaves the held word unchanged.
- R8: `pin_ready` is 1 exactly when the input register is empty. When `pin_valid` and `pin_ready` are both 1 at an edge, `pin_data` is stored and `pin_ready` drops in the next cycle.
- R9: An accepted data-in command with a word held gives `bus_rvalid`=1 in the next cycle, with that word on `bus_rdata`, and empties the register. `pin_ready` returns to 1 in that same cycle.
- R10: A data-in command with the input register empty returns the last word the register held (zero after reset) and sets the error flag.
- R11: Synchronous active-high `rst` empties both registers and clears busy, error, `bus_rvalid`, `ctl_pulse` and `ctl_func`.
- R12: `bus_rdata` is zero in every cycle where `bus_rvalid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Device address on the I/O bus |
| bus_cmd | input | 2 | Command code |
| bus_stb | input | 1 | Command strobe |
| bus_wdata | input | DATA_W | Processor write data / control function |
| bus_rdata | output | DATA_W | Read return data, zero when idle |
| bus_rvalid | output | 1 | Read return qualifier |
| ctl_pulse | output | 1 | One-cycle control command pulse |
| ctl_func | output | FUNC_W | Last control function value |
| pout_valid | output | 1 | Outgoing word available to device |
| pout_ready | input | 1 | Device takes outgoing word |
| pout_data | output | DATA_W | Outgoing word |
| pin_valid | input | 1 | Device offers a word |
| pin_ready | output | 1 | Input register empty |
| pin_data | input | DATA_W | Incoming word |

## Verification
A directed sequence first uses each command class once on its own: control, status, a data-out/drain pair and a device-word/read pair. This separates errors in command decoding from errors in the register paths. It then repeats the same commands at a neighbouring address and with each register in the wrong fill state. These cases tell the address gate apart from the overrun and underrun handling, and show whether a zero or a non-zero function clears the error flag. A long randomized phase follows. It mixes commands at matching and non-matching addresses with random device stalls on both streams. Every output is compared each cycle with a behavioural model, which exposes ordering faults when a command and a device handshake fall in the same cycle.

// File: rtl/bio_pkg.sv
package bio_pkg;

  typedef enum logic [1:0] {
    CMD_CTRL = 2'b00,
    CMD_STAT = 2'b01,
    CMD_DOUT = 2'b10,
    CMD_DIN  = 2'b11
  } bio_cmd_e;

  typedef struct packed {
    logic ctrl;
    logic stat;
    logic dout;
    logic din;
  } bio_req_t;

  localparam int STAT_BUSY    = 0;
  localparam int STAT_ERR     = 1;
  localparam int STAT_IN_FULL = 2;
  localparam int STAT_OUT_MT  = 3;
  localparam int STAT_BITS    = 4;

endpackage

// File: rtl/bio_decode.sv
module bio_decode
  import bio_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] DEV_ADDR = '0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        cmd,
  input  logic              stb,
  output bio_req_t          req
);

  logic [ADDR_W-1:0] bit_eq;
  logic              hit;

  for (genvar i = 0; i < ADDR_W; i++) begin : g_cmp
    assign bit_eq[i] = ~(addr[i] ^ DEV_ADDR[i]);
  end

  assign hit = stb & (&bit_eq);

  always_comb begin
    req = '0;
    if (hit) begin
      unique case (bio_cmd_e'(cmd))
        CMD_CTRL: req.ctrl = 1'b1;
        CMD_STAT: req.stat = 1'b1;
        CMD_DOUT: req.dout = 1'b1;
        CMD_DIN:  req.din  = 1'b1;
        default:  req      = '0;
      endcase
    end
  end

endmodule

// File: rtl/bio_out_buf.sv
module bio_out_buf #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pout_ready,
  output logic              pout_valid,
  output logic [DATA_W-1:0] pout_data,
  output logic              overrun
);

  logic              full_q;
  logic [DATA_W-1:0] word_q;

  assign overrun    = wr_req & full_q;
  assign pout_valid = full_q;
  assign pout_data  = word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      word_q <= '0;
    end else if (full_q) begin
      if (pout_ready) full_q <= 1'b0;
    end else if (wr_req) begin
      full_q <= 1'b1;
      word_q <= wr_data;
    end
  end

endmodule

// File: rtl/bio_in_buf.sv
module bio_in_buf #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pin_valid,
  input  logic [DATA_W-1:0] pin_data,
  output logic              pin_ready,
  input  logic              rd_req,
  output logic [DATA_W-1:0] held_word,
  output logic              full,
  output logic              underrun
);

  logic              full_q;
  logic [DATA_W-1:0] word_q;

  assign pin_ready = ~full_q;
  assign full      = full_q;
  assign held_word = word_q;
  assign underrun  = rd_req & ~full_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      word_q <= '0;
    end else if (full_q) begin
      if (rd_req) full_q <= 1'b0;
    end else if (pin_valid) begin
      full_q <= 1'b1;
      word_q <= pin_data;
    end
  end

endmodule

// File: rtl/bio_resp.sv
module bio_resp
  import bio_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FUNC_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  bio_req_t          req,
  input  logic [FUNC_W-1:0] func_in,
  input  logic              busy,
  input  logic              in_full,
  input  logic [DATA_W-1:0] in_word,
  input  logic              overrun,
  input  logic              underrun,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              ctl_pulse,
  output logic [FUNC_W-1:0] ctl_func
);

  logic              err_q;
  logic [DATA_W-1:0] stat_word;
  logic              err_clr;
  logic              err_set;

  always_comb begin
    stat_word               = '0;
    stat_word[STAT_BUSY]    = busy;
    stat_word[STAT_ERR]     = err_q;
    stat_word[STAT_IN_FULL] = in_full;
    stat_word[STAT_OUT_MT]  = ~busy;
  end

  assign err_clr = req.ctrl & (func_in == '0);
  assign err_set = overrun | underrun;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q     <= 1'b0;
      rvalid    <= 1'b0;
      rdata     <= '0;
      ctl_pulse <= 1'b0;
      ctl_func  <= '0;
    end else begin
      rvalid    <= req.stat | req.din;
      ctl_pulse <= req.ctrl;
      if (req.ctrl) ctl_func <= func_in;
      if (req.stat)      rdata <= stat_word;
      else if (req.din)  rdata <= in_word;
      else               rdata <= '0;
      if (err_set)       err_q <= 1'b1;
      else if (err_clr)  err_q <= 1'b0;
    end
  end

endmodule

// File: rtl/bus_io_port.sv
module bus_io_port
  import bio_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 16,
  parameter int                FUNC_W   = 8,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 8'h3C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_cmd,
  input  logic              bus_stb,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              ctl_pulse,
  output logic [FUNC_W-1:0] ctl_func,
  output logic              pout_valid,
  input  logic              pout_ready,
  output logic [DATA_W-1:0] pout_data,
  input  logic              pin_valid,
  output logic              pin_ready,
  input  logic [DATA_W-1:0] pin_data
);

  localparam int FW = (FUNC_W < DATA_W) ? FUNC_W : DATA_W;

  bio_req_t          req;
  logic              overrun;
  logic              underrun;
  logic              in_full;
  logic [DATA_W-1:0] in_word;
  logic [FUNC_W-1:0] func_val;

  always_comb begin
    func_val       = '0;
    func_val[FW-1:0] = bus_wdata[FW-1:0];
  end

  bio_decode #(.ADDR_W(ADDR_W), .DEV_ADDR(DEV_ADDR)) u_dec (
    .addr (bus_addr),
    .cmd  (bus_cmd),
    .stb  (bus_stb),
    .req  (req)
  );

  bio_out_buf #(.DATA_W(DATA_W)) u_obuf (
    .clk        (clk),
    .rst        (rst),
    .wr_req     (req.dout),
    .wr_data    (bus_wdata),
    .pout_ready (pout_ready),
    .pout_valid (pout_valid),
    .pout_data  (pout_data),
    .overrun    (overrun)
  );

  bio_in_buf #(.DATA_W(DATA_W)) u_ibuf (
    .clk       (clk),
    .rst       (rst),
    .pin_valid (pin_valid),
    .pin_data  (pin_data),
    .pin_ready (pin_ready),
    .rd_req    (req.din),
    .held_word (in_word),
    .full      (in_full),
    .underrun  (underrun)
  );

  bio_resp #(.DATA_W(DATA_W), .FUNC_W(FUNC_W)) u_resp (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .func_in   (func_val),
    .busy      (pout_valid),
    .in_full   (in_full),
    .in_word   (in_word),
    .overrun   (overrun),
    .underrun  (underrun),
    .rdata     (bus_rdata),
    .rvalid    (bus_rvalid),
    .ctl_pulse (ctl_pulse),
    .ctl_func  (ctl_func)
  );

endmodule

// File: rtl/bio_chk.sv
module bio_chk #(
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 16,
  parameter int                FUNC_W   = 8,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 8'h3C
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_cmd,
  input logic              bus_stb,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_rvalid,
  input logic              ctl_pulse,
  input logic [FUNC_W-1:0] ctl_func,
  input logic              pout_valid,
  input logic              pout_ready,
  input logic [DATA_W-1:0] pout_data,
  input logic              pin_valid,
  input logic              pin_ready
);

  logic sel;
  assign sel = bus_stb && (bus_addr == DEV_ADDR);

  p_unsel_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !sel |=> (!bus_rvalid && !ctl_pulse));

  p_ctl_func_r3: assert property (@(posedge clk) disable iff (rst)
    (sel && bus_cmd == 2'b00) |=> (ctl_pulse && ctl_func == $past(bus_wdata[FUNC_W-1:0])));

  p_status_word_r4: assert property (@(posedge clk) disable iff (rst)
    (sel && bus_cmd == 2'b01) |=> (bus_rvalid && bus_rdata[DATA_W-1:4] == '0
      && bus_rdata[0] == $past(pout_valid) && bus_rdata[2] == $past(!pin_ready)
      && bus_rdata[3] == $past(!pout_valid)));

  p_dout_load_r5: assert property (@(posedge clk) disable iff (rst)
    (sel && bus_cmd == 2'b10 && !pout_valid) |=> (pout_valid && pout_data == $past(bus_wdata)));

  p_pout_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (pout_valid && !pout_ready) |=> (pout_valid && $stable(pout_data)));

  p_pout_drain_r6: assert property (@(posedge clk) disable iff (rst)
    (pout_valid && pout_ready) |=> !pout_valid);

  p_pin_fill_r8: assert property (@(posedge clk) disable iff (rst)
    (pin_valid && pin_ready) |=> !pin_ready);

  p_din_free_r9: assert property (@(posedge clk) disable iff (rst)
    (sel && bus_cmd == 2'b11 && !pin_ready) |=> (pin_ready && bus_rvalid));

  p_idle_zero_r12: assert property (@(posedge clk) disable iff (rst)
    !bus_rvalid |-> (bus_rdata == '0));

endmodule

bind bus_io_port bio_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FUNC_W(FUNC_W), .DEV_ADDR(DEV_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_cmd(bus_cmd), .bus_stb(bus_stb),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
  .ctl_pulse(ctl_pulse), .ctl_func(ctl_func), .pout_valid(pout_valid),
  .pout_ready(pout_ready), .pout_data(pout_data), .pin_valid(pin_valid),
  .pin_ready(pin_ready)
);

// File: tb/bus_io_port_tb_top.sv
`timescale 1ns/1ps
module bus_io_port_tb_top;

  localparam logic [7:0] DEV = 8'h3C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic [1:0]  bus_cmd = '0;
  logic        bus_stb = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_rvalid;
  logic        ctl_pulse;
  logic [7:0]  ctl_func;
  logic        pout_valid;
  logic        pout_ready = 1'b0;
  logic [15:0] pout_data;
  logic        pin_valid = 1'b0;
  logic        pin_ready;
  logic [15:0] pin_data = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  bus_io_port #(.ADDR_W(8), .DATA_W(16), .FUNC_W(8), .DEV_ADDR(DEV)) dut_i (.*);

  // behavioural reference model
  bit          m_ofull, m_ifull, m_err, m_rvalid, m_pulse;
  logic [15:0] m_odata, m_idata, m_rdata;
  logic [7:0]  m_func;

  always @(posedge clk) begin
    bit          n_ofull, n_ifull, n_err, n_rvalid, n_pulse;
    logic [15:0] n_odata, n_idata, n_rdata;
    logic [7:0]  n_func;
    if (rst) begin
      m_ofull = 0; m_ifull = 0; m_err = 0; m_rvalid = 0; m_pulse = 0;
      m_odata = '0; m_idata = '0; m_rdata = '0; m_func = '0;
    end else begin
      n_ofull = m_ofull; n_ifull = m_ifull; n_err = m_err;
      n_odata = m_odata; n_idata = m_idata; n_func = m_func;
      n_rvalid = 0; n_pulse = 0; n_rdata = '0;
      if (m_ofull && pout_ready) n_ofull = 0;
      if (!m_ifull && pin_valid) begin n_ifull = 1; n_idata = pin_data; end
      if (bus_stb && bus_addr == DEV) begin
        case (bus_cmd)
          2'b00: begin n_pulse = 1; n_func = bus_wdata[7:0]; if (bus_wdata[7:0] == 0) n_err = 0; end
          2'b01: begin n_rvalid = 1; n_rdata = {12'h0, !m_ofull, m_ifull, m_err, m_ofull}; end
          2'b10: if (m_ofull) n_err = 1; else begin n_ofull = 1; n_odata = bus_wdata; end
          default: begin n_rvalid = 1; n_rdata = m_idata; if (m_ifull) n_ifull = 0; else n_err = 1; end
        endcase
      end
      m_ofull = n_ofull; m_ifull = n_ifull; m_err = n_err; m_odata = n_odata;
      m_idata = n_idata; m_func = n_func; m_rvalid = n_rvalid; m_pulse = n_pulse; m_rdata = n_rdata;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) if (!rst && !done) begin
    chk("R4/R9/R10 rvalid", bus_rvalid, m_rvalid);
    chk("R12 rdata", bus_rdata, m_rdata);
    chk("R3 ctl_pulse", ctl_pulse, m_pulse);
    chk("R3 ctl_func", ctl_func, m_func);
    chk("R5/R6 pout_valid", pout_valid, m_ofull);
    if (m_ofull) chk("R7 pout_data", pout_data, m_odata);
    chk("R8 pin_ready", pin_ready, !m_ifull);
  end

  task automatic bus_op(logic [7:0] a, logic [1:0] c, logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_cmd = c; bus_wdata = d; bus_stb = 1'b1;
    @(negedge clk);
    bus_stb = 1'b0;
  endtask

  task automatic dev_take();
    @(negedge clk); pout_ready = 1'b1;
    @(negedge clk); pout_ready = 1'b0;
  endtask

  task automatic dev_give(logic [15:0] d);
    @(negedge clk); pin_valid = 1'b1; pin_data = d;
    @(negedge clk); pin_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 pout_valid", pout_valid, 0);
    chk("R11 pin_ready", pin_ready, 1);
    chk("R11 rvalid", bus_rvalid, 0);
    chk("R11 ctl_pulse", ctl_pulse, 0);
    // R4 status after reset: only out-empty bit 3
    bus_op(DEV, 2'b01, 0);
    chk("R4 status idle", bus_rdata, 16'h0008);
    // R3 control function (R2 code 00)
    bus_op(DEV, 2'b00, 16'h0005);
    chk("R3 pulse", ctl_pulse, 1);
    chk("R3 func", ctl_func, 8'h05);
    // R1 wrong address ignored
    bus_op(DEV ^ 8'h01, 2'b10, 16'hBEEF);
    chk("R1 no load", pout_valid, 0);
    chk("R1 no response", bus_rvalid, 0);
    // R5 data out, device stalled
    bus_op(DEV, 2'b10, 16'hA5A5);
    chk("R5 valid", pout_valid, 1);
    chk("R5 data", pout_data, 16'hA5A5);
    bus_op(DEV, 2'b01, 0);
    chk("R5 busy status", bus_rdata, 16'h0001);
    // R7 overrun
    bus_op(DEV, 2'b10, 16'h1111);
    chk("R7 word kept", pout_data, 16'hA5A5);
    bus_op(DEV, 2'b01, 0);
    chk("R7 error status", bus_rdata, 16'h0003);
    // R3 nonzero function keeps error, zero clears it
    bus_op(DEV, 2'b00, 16'h0003);
    bus_op(DEV, 2'b01, 0);
    chk("R3 err kept", bus_rdata, 16'h0003);
    bus_op(DEV, 2'b00, 16'h0000);
    bus_op(DEV, 2'b01, 0);
    chk("R3 err cleared", bus_rdata, 16'h0001);
    // R6 drain
    dev_take();
    chk("R6 drained", pout_valid, 0);
    // R10 read empty input register
    bus_op(DEV, 2'b11, 0);
    chk("R10 prev word", bus_rdata, 16'h0000);
    bus_op(DEV, 2'b01, 0);
    chk("R10 error status", bus_rdata, 16'h000A);
    // R8 device delivers
    dev_give(16'h1234);
    chk("R8 ready low", pin_ready, 0);
    bus_op(DEV, 2'b01, 0);
    chk("R8 full status", bus_rdata, 16'h000E);
    // R9 read full
    bus_op(DEV, 2'b11, 0);
    chk("R9 word", bus_rdata, 16'h1234);
    chk("R9 ready back", pin_ready, 1);
    bus_op(DEV, 2'b11, 0);
    chk("R10 repeat prev", bus_rdata, 16'h1234);
    // R1 / R12 unselected read
    bus_op(8'h00, 2'b01, 0);
    chk("R12 idle rdata", bus_rdata, 0);
    chk("R1 idle rvalid", bus_rvalid, 0);
    // randomized phase, model compared every cycle
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      bus_stb    = ($urandom % 2) == 0;
      bus_addr   = ($urandom % 3 == 0) ? (DEV ^ 8'h10) : DEV;
      bus_cmd    = 2'($urandom);
      bus_wdata  = ($urandom % 4 == 0) ? 16'h0 : 16'($urandom);
      pout_ready = ($urandom % 3) == 0;
      pin_valid  = ($urandom % 3) == 0;
      pin_data   = 16'($urandom);
    end
    @(negedge clk);
    bus_stb = 0; pout_ready = 0; pin_valid = 0;
    @(negedge clk);
    // R11 reset mid-traffic
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 post pout_valid", pout_valid, 0);
    chk("R11 post pin_ready", pin_ready, 1);
    chk("R11 post func", ctl_func, 0);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule